// File: doc/BRIEF.md
# Radix-4 Booth Recoded Multiplier

This block multiplies an N-bit multiplicand by an N-bit multiplier and returns the full 2N-bit product one clock after the operands are presented. The multiplier operand is recoded in radix 4. A zero bit is placed below its least significant bit. Its upper end is extended so that it splits into overlapping three-bit windows that advance by two bit positions. Each window becomes one signed digit in {-2, -1, 0, +1, +2}. That digit scales the multiplicand by selection, a one-bit shift and two's-complement negation only, so no triple of the multiplicand is ever formed. The scaled terms are weighted by powers of four and summed.

A per-operation mode input treats both operands either as unsigned or as two's-complement numbers. In unsigned mode the multiplier is zero-extended. This gives N/2+1 windows for even N and (N+1)/2 for odd N. In signed mode the multiplier is sign-extended, and for even N the topmost window is dropped, leaving N/2 digits. A valid strobe travels alongside the data. The product register loads only on a valid operation and otherwise keeps its value.

Top module: `booth4_mul`

## Requirements
- R1: While reset is asserted and after it is released with no operation issued, `out_valid` is 0 and `product` is all zeros.
- R2: With `signed_mode`=0, `product` equals the unsigned product of `mcand` and `mplier`, exact in 2N bits.
- R3: With `signed_mode`=1, `product` equals the two's-complement product of `mcand` and `mplier`, exact in 2N bits. For nonzero operands, its top bit is the XOR of the two operand sign bits.
- R4: Each window (upper, middle, lower bit) is recoded so that 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. A digit is never both one and two, and it is never negative zero.
- R5: `out_valid` is high in exactly the cycles that follow a rising clock edge at which `in_valid` was high.
- R6: When `in_valid` is low, the operands and mode are ignored and `product` keeps its previous value.
- R7: In signed mode with even N, only N/2 digits contribute, and the topmost window's digit is forced to 0. Products involving the most negative value stay exact.
- R8: In signed 8-bit mode, multiplicand 0x95 (-107) times multiplier 0x69 (105) yields 0xD41D (-11235).
- R9: A zero multiplicand on a valid operation yields a zero product in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier, the recoded operand |
| out_valid | output | 1 | Product register holds a new result |
| product | output | 2N | Registered 2N-bit product |

## Verification
The assertions assume that `in_valid` and `signed_mode` are known (never X or Z) on every clock edge after reset, and that operands are known whenever `in_valid` is high. The sign-of-product property also relies on operands being stable between the sampling edge and the check one cycle later. The bench meets these conditions by driving every input from a single procedure on the falling clock edge, holding `in_valid` low throughout reset, and sweeping every operand pair in both modes with known values only. Any idle cycles it inserts leave the inputs at defined but deliberately different values.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // One radix-4 signed digit: magnitude select (one or two) and sign.
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } bdigit_t;

  localparam bdigit_t DIG_ZERO = '{neg: 1'b0, two: 1'b0, one: 1'b0};

  // Window {upper, middle, lower} -> signed digit.
  function automatic bdigit_t recode(input logic [2:0] win);
    bdigit_t d;
    unique case (win)
      3'b001, 3'b010: d = '{neg: 1'b0, two: 1'b0, one: 1'b1};
      3'b011:         d = '{neg: 1'b0, two: 1'b1, one: 1'b0};
      3'b100:         d = '{neg: 1'b1, two: 1'b1, one: 1'b0};
      3'b101, 3'b110: d = '{neg: 1'b1, two: 1'b0, one: 1'b1};
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder
  import booth4_pkg::*;
#(
  parameter int W  = 8,
  parameter int NG = (W + 2) / 2
) (
  input  logic                 signed_mode,
  input  logic [W-1:0]         mplier,
  output bdigit_t [NG-1:0]     digits
);

  localparam int EXT_BITS = 2 * NG - W;
  localparam bit TRIM_TOP = (W % 2 == 0);

  logic              ext_bit;
  logic [2*NG:0]     padded;

  assign ext_bit = signed_mode & mplier[W-1];
  assign padded  = {{EXT_BITS{ext_bit}}, mplier, 1'b0};

  for (genvar k = 0; k < NG; k++) begin : g_win
    bdigit_t raw;
    assign raw = recode(padded[2*k+2 -: 3]);
    if (TRIM_TOP && (k == NG - 1)) begin : g_trim
      assign digits[k] = signed_mode ? DIG_ZERO : raw;
    end else begin : g_keep
      assign digits[k] = raw;
    end
  end

endmodule

// File: rtl/booth4_ppgen.sv
module booth4_ppgen
  import booth4_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           signed_mode,
  input  logic [W-1:0]   mcand,
  input  bdigit_t        digit,
  output logic [W+1:0]   pp
);

  localparam int PW = W + 2;

  logic [PW-1:0] ext;
  logic [PW-1:0] mag;

  assign ext = {{2{signed_mode & mcand[W-1]}}, mcand};

  always_comb begin
    if (digit.two)      mag = ext << 1;
    else if (digit.one) mag = ext;
    else                mag = '0;
    pp = digit.neg ? (~mag + PW'(1)) : mag;
  end

endmodule

// File: rtl/booth4_accum.sv
module booth4_accum #(
  parameter int W  = 8,
  parameter int NG = (W + 2) / 2
) (
  input  logic [NG-1:0][W+1:0] pps,
  output logic [2*W-1:0]       sum
);

  localparam int RW = 2 * W;

  function automatic logic [RW-1:0] weigh_and_add(input logic [NG-1:0][W+1:0] terms);
    logic [RW-1:0] acc;
    logic [RW-1:0] ext;
    acc = '0;
    for (int k = 0; k < NG; k++) begin
      ext = RW'($signed(terms[k]));
      acc = acc + (ext << (2 * k));
    end
    return acc;
  endfunction

  assign sum = weigh_and_add(pps);

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             signed_mode,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  output logic             out_valid,
  output logic [2*W-1:0]   product
);

  localparam int NG = (W + 2) / 2;
  localparam int PW = W + 2;

  bdigit_t [NG-1:0]     digits;
  logic [NG-1:0][PW-1:0] pps;
  logic [2*W-1:0]       sum_comb;

  booth4_recoder #(.W(W), .NG(NG)) u_rec (
    .signed_mode (signed_mode),
    .mplier      (mplier),
    .digits      (digits)
  );

  for (genvar k = 0; k < NG; k++) begin : g_pp
    booth4_ppgen #(.W(W)) u_pp (
      .signed_mode (signed_mode),
      .mcand       (mcand),
      .digit       (digits[k]),
      .pp          (pps[k])
    );
  end

  booth4_accum #(.W(W), .NG(NG)) u_acc (
    .pps (pps),
    .sum (sum_comb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= sum_comb;
    end
  end

endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk
  import booth4_pkg::*;
#(
  parameter int W  = 8,
  parameter int NG = (W + 2) / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             signed_mode,
  input logic [W-1:0]     mcand,
  input logic [W-1:0]     mplier,
  input logic             out_valid,
  input logic [2*W-1:0]   product,
  input bdigit_t [NG-1:0] digits
);

  localparam bit TRIM_TOP = (W % 2 == 0);

  p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  p_zero_mcand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mcand == '0) |=> (product == '0));

  p_sign_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && mcand != '0 && mplier != '0)
      |=> (product[2*W-1] == ($past(mcand[W-1]) ^ $past(mplier[W-1]))));

  for (genvar k = 0; k < NG; k++) begin : g_dig
    p_digit_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(digits[k].two && digits[k].one) &&
      !(digits[k].neg && !digits[k].two && !digits[k].one));
  end

  if (TRIM_TOP) begin : g_trim
    p_top_digit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      signed_mode |-> (digits[NG-1] == DIG_ZERO));
  end

endmodule

bind booth4_mul booth4_mul_chk #(.W(W), .NG(NG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .signed_mode (signed_mode),
  .mcand       (mcand),
  .mplier      (mplier),
  .out_valid   (out_valid),
  .product     (product),
  .digits      (digits)
);

// File: tb/booth4_mul_test.sv
module booth4_mul_test;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           signed_mode;
  logic [W-1:0]   mcand;
  logic [W-1:0]   mplier;
  logic           out_valid;
  logic [2*W-1:0] product;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  booth4_mul #(.W(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .signed_mode (signed_mode),
    .mcand       (mcand),
    .mplier      (mplier),
    .out_valid   (out_valid),
    .product     (product)
  );

  // Arithmetic model: interpret operands per mode, multiply as integers.
  function automatic logic [2*W-1:0] model(input bit sm, input int a, input int b);
    int sa = a;
    int sb = b;
    if (sm && a >= (1 << (W - 1))) sa = a - (1 << W);
    if (sm && b >= (1 << (W - 1))) sb = b - (1 << W);
    return (2*W)'(sa * sb);
  endfunction

  task automatic check(input string tag, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=%0d cycles expected=completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] exp_q;
    string          tag_q;
    bit             pend;
    logic [2*W-1:0] last;

    rst_n = 1'b0;
    in_valid = 1'b0;
    signed_mode = 1'b0;
    mcand = '0;
    mplier = '0;
    pend = 0;
    exp_q = '0;
    tag_q = "";

    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {15'b0, out_valid}, '0);
    check("R1 product in reset", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {15'b0, out_valid}, '0);
    check("R1 product after reset", product, '0);

    // Exhaustive sweep, one operation per cycle, checked one cycle later.
    for (int sm = 0; sm < 2; sm++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          @(negedge clk);
          if (pend) begin
            check(tag_q, product, exp_q);
            check("R5 out_valid after op", {15'b0, out_valid}, 16'd1);
          end
          in_valid    = 1'b1;
          signed_mode = sm[0];
          mcand       = W'(a);
          mplier      = W'(b);
          exp_q       = model(sm[0], a, b);
          if (a == 0)                              tag_q = "R9 zero multiplicand";
          else if (sm == 1 && (a == 128 || b == 128)) tag_q = "R7 most-negative operand";
          else if (sm == 1)                        tag_q = "R3/R4 signed sweep";
          else                                     tag_q = "R2/R4 unsigned sweep";
          pend = 1;
        end
      end
    end

    @(negedge clk);
    check(tag_q, product, exp_q);
    last = product;

    // Idle cycles with changed inputs: output must hold, valid must drop.
    in_valid    = 1'b0;
    signed_mode = 1'b0;
    mcand       = 8'hA5;
    mplier      = 8'h3C;
    @(negedge clk);
    check("R5 out_valid low after idle", {15'b0, out_valid}, '0);
    check("R6 product held", product, last);
    mcand  = 8'h77;
    mplier = 8'hFF;
    @(negedge clk);
    check("R6 product held second idle", product, last);

    // Worked signed example.
    in_valid    = 1'b1;
    signed_mode = 1'b1;
    mcand       = 8'h95;
    mplier      = 8'h69;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 -107 x 105", product, 16'hD41D);
    check("R5 out_valid after worked example", {15'b0, out_valid}, 16'd1);

    // Unsigned all-ones corner.
    in_valid    = 1'b1;
    signed_mode = 1'b0;
    mcand       = 8'hFF;
    mplier      = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 all-ones unsigned", product, 16'hFE01);

    // Signed most-negative squared.
    in_valid    = 1'b1;
    signed_mode = 1'b1;
    mcand       = 8'h80;
    mplier      = 8'h80;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 most-negative squared", product, 16'h4000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule